// File: doc/BRIEF.md
# PMA-Safe Reconfiguration Sequencer

This block is a host-side control state machine that switches a transceiver channel to a new configuration profile. It does the switch by driving a memory-mapped master port into a reconfiguration streamer. A requester presents a profile number and a flag. The flag says whether the new profile can only be loaded while the analog PMA is switched off. The sequencer accepts the request only while it is idle, and it reports the outcome with a single-cycle done or error pulse.

When the flag is clear, the sequencer writes the launch word and then polls the streamer's status word until the busy bit clears. When the flag is set, it first raises the channel's digital reset and writes the PMA-disable attribute code. Only then does it launch and poll, and it drops digital reset once loading has finished. It sends no recalibration command, because the streamer requests recalibration by itself. Polls are separated by a programmable idle gap. A poll budget bounds how long the sequencer waits, and when that budget runs out it aborts, releases reset and signals an error.

Top module: `reconf_seq`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `av_read`=0, `av_write`=0, `dig_reset`=0, `done`=0, `err`=0.
- R2: With `req_pma_off`=1, `dig_reset` rises the cycle after acceptance. The first bus operation is a write of data 0x00000001 to the attribute address (default 0x40144), and `dig_reset` stays high through every following write and poll read.
- R3: The launch is a write to 0x40140 whose data has bits [5:0] equal to the profile, bit 7 equal to 1 and every other bit 0. With `req_pma_off`=0 this launch is the first bus operation, and `dig_reset` stays 0 for the whole sequence.
- R4: After the launch the block issues only reads, all to 0x40141. It stops once a read returns bit 0 equal to 0.
- R5: While `av_waitrequest` is high, a pending read or write stays asserted with unchanged address and data. No read and write are asserted together.
- R6: After a read returns bit 0 = 1, the next read is asserted exactly `poll_gap`+1 cycles after the cycle in which `av_readdatavalid` was high.
- R7: On success `done` pulses high for exactly one cycle. In the simple path this pulse comes one cycle after the final read data. In the PMA-off path `dig_reset` falls one cycle after the final read data, and `done` pulses one cycle after that.
- R8: A busy response that brings the count of busy responses to `poll_limit` (with 0 treated as 1) ends the sequence. `err` pulses one cycle later, `dig_reset` is already 0 in that cycle, no `done` is produced and the block returns to idle.
- R9: While not idle, `req_ready`=0 and any `req_valid` is ignored. The profile, flag, gap and limit used are those captured when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when `req_ready` is high |
| req_profile | input | 6 | Target profile number |
| req_pma_off | input | 1 | New profile needs the PMA disabled |
| poll_gap | input | 8 | Idle cycles between a busy response and the next poll |
| poll_limit | input | 12 | Maximum number of busy responses before abort |
| req_ready | output | 1 | High while idle |
| av_address | output | 19 | Master address |
| av_write | output | 1 | Master write request |
| av_read | output | 1 | Master read request |
| av_writedata | output | 32 | Master write data |
| av_readdata | input | 32 | Read data, bit 0 is the busy flag |
| av_readdatavalid | input | 1 | Read data valid |
| av_waitrequest | input | 1 | Slave stall |
| dig_reset | output | 1 | Channel digital reset |
| done | output | 1 | Success pulse |
| err | output | 1 | Poll-timeout pulse |

## Verification
The hardest situation to reach is the poll budget running out on the PMA-off path. In that case the block must release digital reset and raise the error while skipping done, and the budget edge (busy count one below the limit, and a limit of zero) must be handled correctly. The bench's streamer model is told, for each request, how many busy responses to return before it reports idle. This lets the stimulus set the busy count just under, at, and above the limit, while stalling bus transfers through a repeating waitrequest pattern. A second request driven in the middle of a sequence checks that the captured profile is the one launched.

// File: rtl/reconf_seq.sv
module reconf_seq #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int PROF_W = 6,
  parameter int GAP_W  = 8,
  parameter int TMO_W  = 12,
  parameter int GO_BIT = 7,
  parameter logic [ADDR_W-1:0] LAUNCH_ADDR = 19'h40140,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 19'h40141,
  parameter logic [ADDR_W-1:0] ATTR_ADDR   = 19'h40144,
  parameter logic [DATA_W-1:0] PMA_OFF_CODE = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PROF_W-1:0] req_profile,
  input  logic              req_pma_off,
  input  logic [GAP_W-1:0]  poll_gap,
  input  logic [TMO_W-1:0]  poll_limit,
  output logic              req_ready,
  output logic [ADDR_W-1:0] av_address,
  output logic              av_write,
  output logic              av_read,
  output logic [DATA_W-1:0] av_writedata,
  input  logic [DATA_W-1:0] av_readdata,
  input  logic              av_readdatavalid,
  input  logic              av_waitrequest,
  output logic              dig_reset,
  output logic              done,
  output logic              err
);

  typedef enum logic [3:0] {
    S_IDLE, S_ATTR, S_LAUNCH, S_RD, S_WAIT, S_GAP, S_REL, S_DONE, S_ERR
  } st_t;

  st_t               st;
  logic [PROF_W-1:0] prof;
  logic              pma;
  logic [GAP_W-1:0]  gap_r, gap_cnt;
  logic [TMO_W-1:0]  lim_r, tries;
  logic              dig;
  logic [DATA_W-1:0] launch_word;
  logic              busy, limit_hit;
  logic              unused_rd;

  assign busy      = av_readdata[0];
  assign unused_rd = ^av_readdata[DATA_W-1:1];
  assign limit_hit = (tries + 1'b1) >= lim_r;

  always_comb begin
    launch_word = '0;
    launch_word[PROF_W-1:0] = prof;
    launch_word[GO_BIT] = 1'b1;
  end

  assign req_ready    = (st == S_IDLE);
  assign av_write     = (st == S_ATTR) || (st == S_LAUNCH);
  assign av_read      = (st == S_RD);
  assign av_address   = (st == S_ATTR) ? ATTR_ADDR :
                        (st == S_LAUNCH) ? LAUNCH_ADDR : STATUS_ADDR;
  assign av_writedata = (st == S_ATTR) ? PMA_OFF_CODE :
                        (st == S_LAUNCH) ? launch_word : '0;
  assign dig_reset    = dig;
  assign done         = (st == S_DONE);
  assign err          = (st == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      prof    <= '0;
      pma     <= 1'b0;
      gap_r   <= '0;
      gap_cnt <= '0;
      lim_r   <= '0;
      tries   <= '0;
      dig     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          prof  <= req_profile;
          pma   <= req_pma_off;
          gap_r <= poll_gap;
          lim_r <= poll_limit;
          tries <= '0;
          if (req_pma_off) begin
            dig <= 1'b1;
            st  <= S_ATTR;
          end else begin
            st  <= S_LAUNCH;
          end
        end
        S_ATTR:   if (!av_waitrequest) st <= S_LAUNCH;
        S_LAUNCH: if (!av_waitrequest) st <= S_RD;
        S_RD:     if (!av_waitrequest) st <= S_WAIT;
        S_WAIT: if (av_readdatavalid) begin
          if (!busy) begin
            dig <= 1'b0;
            st  <= pma ? S_REL : S_DONE;
          end else if (limit_hit) begin
            dig <= 1'b0;
            st  <= S_ERR;
          end else begin
            tries   <= tries + 1'b1;
            gap_cnt <= gap_r;
            st      <= (gap_r == '0) ? S_RD : S_GAP;
          end
        end
        S_GAP: begin
          gap_cnt <= gap_cnt - 1'b1;
          if (gap_cnt == 1) st <= S_RD;
        end
        S_REL:  st <= S_DONE;
        S_DONE: st <= S_IDLE;
        S_ERR:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/reconf_seq_chk.sv
module reconf_seq_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int GO_BIT = 7,
  parameter logic [ADDR_W-1:0] LAUNCH_ADDR = 19'h40140,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 19'h40141,
  parameter logic [ADDR_W-1:0] ATTR_ADDR   = 19'h40144
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] av_address,
  input logic              av_write,
  input logic              av_read,
  input logic [DATA_W-1:0] av_writedata,
  input logic              av_waitrequest,
  input logic              dig_reset,
  input logic              done,
  input logic              err
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!av_read && !av_write && !dig_reset)); // R1

  AST_ATTR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (av_write && av_address == ATTR_ADDR) |-> dig_reset); // R2

  AST_LAUNCH_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (av_write && av_address == LAUNCH_ADDR) |-> av_writedata[GO_BIT]); // R3

  AST_READ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    av_read |-> (av_address == STATUS_ADDR)); // R4

  AST_NO_DUAL_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(av_read && av_write)); // R5

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (av_write && av_waitrequest) |=> (av_write && $stable(av_address) && $stable(av_writedata))); // R5

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (av_read && av_waitrequest) |=> (av_read && $stable(av_address))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dig_reset); // R7

  AST_ERR_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!dig_reset && !done)); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (av_read || av_write || done || err) |-> !req_ready); // R9

endmodule

bind reconf_seq reconf_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GO_BIT(GO_BIT),
  .LAUNCH_ADDR(LAUNCH_ADDR), .STATUS_ADDR(STATUS_ADDR), .ATTR_ADDR(ATTR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .av_address(av_address),
  .av_write(av_write), .av_read(av_read), .av_writedata(av_writedata),
  .av_waitrequest(av_waitrequest), .dig_reset(dig_reset), .done(done), .err(err)
);

// File: tb/sim_reconf_seq.sv
`timescale 1ns/1ps
module sim_reconf_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_profile = '0;
  logic        req_pma_off = 1'b0;
  logic [7:0]  poll_gap = '0;
  logic [11:0] poll_limit = '0;
  logic        req_ready, av_write, av_read, dig_reset, done, err;
  logic [18:0] av_address;
  logic [31:0] av_writedata;
  logic [31:0] av_readdata = '0;
  logic        av_readdatavalid = 1'b0;
  logic        av_waitrequest = 1'b0;

  reconf_seq u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // streamer model
  logic       stall_en = 1'b0;
  int         busy_cfg = 0, busy_left = 0;
  logic [2:0] sc = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      sc <= '0; av_waitrequest <= 1'b0; av_readdatavalid <= 1'b0; busy_left <= 0;
    end else begin
      sc <= sc + 1'b1;
      av_waitrequest <= stall_en && (sc == 3'd1 || sc == 3'd4 || sc == 3'd5);
      av_readdatavalid <= av_read && !av_waitrequest;
      if (req_valid && req_ready) busy_left <= busy_cfg;
      if (av_read && !av_waitrequest) begin
        av_readdata <= {31'b0, busy_left != 0};
        if (busy_left > 0) busy_left <= busy_left - 1;
      end
    end
  end

  // scoreboard: {is_read, dig_reset, address, data}
  logic [52:0] expq[$];
  int  n_done = 0, n_err = 0, last_rdv = -1, last_busy = -1, fall_cyc = -1;
  int  done_cyc = -1, err_cyc = -1, cur_gap = 0;
  bit  rd_prev = 0, dig_prev = 0, done_prev = 0, err_dig = 0;

  always @(negedge clk) if (rst_n) begin
    if (req_valid && req_ready) begin last_busy = -1; cur_gap = int'(poll_gap); end
    if ((av_write || av_read) && !av_waitrequest) begin
      logic [52:0] got, exp;
      got = {av_read, dig_reset, av_address, av_writedata};
      if (expq.size() == 0) chk(0, "R4 unexpected bus op", longint'(got), 0);
      else begin
        exp = expq.pop_front();
        chk(got == exp, (exp[50:32] == 19'h40144) ? "R2 attr write" :
                        (exp[50:32] == 19'h40140) ? "R3 launch write" : "R4 poll read",
            longint'(got), longint'(exp));
      end
    end
    if (av_read && !rd_prev && last_busy >= 0)
      chk(cyc - last_busy == cur_gap + 1, "R6 poll gap", cyc - last_busy, cur_gap + 1);
    if (av_readdatavalid) begin
      last_rdv = cyc;
      if (av_readdata[0]) last_busy = cyc;
    end
    if (dig_prev && !dig_reset) fall_cyc = cyc;
    if (done) begin
      n_done++; done_cyc = cyc;
      chk(!done_prev, "R7 done width", 2, 1);
    end
    if (err) begin n_err++; err_cyc = cyc; err_dig = dig_reset; end
    rd_prev = av_read; dig_prev = dig_reset; done_prev = done;
  end

  bit aborted = 0;

  task automatic run(input logic [5:0] prof, input bit pma, input int busy,
                     input int gap, input int lim, input bit stall, input bit poke);
    int  lim_eff, nrd, d0, e0;
    bit  exp_err;
    if (aborted) return;
    lim_eff = (lim == 0) ? 1 : lim;
    exp_err = busy >= lim_eff;
    nrd = exp_err ? lim_eff : busy + 1;
    if (pma) expq.push_back({1'b0, 1'b1, 19'h40144, 32'h1});
    expq.push_back({1'b0, pma, 19'h40140, 24'h0, 2'b10, prof});
    for (int i = 0; i < nrd; i++) expq.push_back({1'b1, pma, 19'h40141, 32'h0});
    stall_en = stall; busy_cfg = busy;
    d0 = n_done; e0 = n_err; fall_cyc = -1;
    @(negedge clk);
    chk(req_ready, "R9 ready before request", req_ready, 1);
    req_valid = 1; req_profile = prof; req_pma_off = pma;
    poll_gap = 8'(gap); poll_limit = 12'(lim);
    @(negedge clk);
    req_valid = 0;
    if (pma) chk(dig_reset, "R2 reset raised after accept", dig_reset, 1);
    else     chk(!dig_reset, "R3 no reset in simple path", dig_reset, 0);
    if (poke) begin
      @(negedge clk);
      chk(!req_ready, "R9 not ready while busy", req_ready, 0);
      req_valid = 1; req_profile = ~prof; req_pma_off = ~pma; poll_gap = 8'(gap + 3);
      @(negedge clk);
      req_valid = 0;
    end
    begin
      int w = 0;
      while (n_done == d0 && n_err == e0 && w < 3000) begin @(negedge clk); w++; end
      if (w >= 3000) begin
        chk(0, "R7 sequence hung", 0, 1);
        aborted = 1;
        return;
      end
    end
    repeat (3) @(negedge clk);
    chk(n_done - d0 == (exp_err ? 0 : 1), "R7 done count", n_done - d0, exp_err ? 0 : 1);
    chk(n_err - e0 == (exp_err ? 1 : 0), "R8 err count", n_err - e0, exp_err ? 1 : 0);
    chk(expq.size() == 0, "R4 missing bus ops", expq.size(), 0);
    chk(!dig_reset && req_ready, "R1 idle after sequence", {dig_reset, req_ready}, 1);
    if (exp_err) begin
      chk(err_cyc == last_rdv + 1, "R8 err timing", err_cyc - last_rdv, 1);
      chk(!err_dig, "R8 reset released at err", err_dig, 0);
    end else begin
      chk(done_cyc == last_rdv + (pma ? 2 : 1), "R7 done timing",
          done_cyc - last_rdv, pma ? 2 : 1);
      if (pma) chk(fall_cyc == done_cyc - 1, "R7 reset falls before done",
                   done_cyc - fall_cyc, 1);
    end
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !av_read && !av_write && !dig_reset && !done && !err,
        "R1 reset state", {req_ready, av_read, av_write, dig_reset, done, err}, 6'b100000);
    run(6'd5,  0, 0, 0, 4, 0, 0); // R3 R4 simple, immediate finish
    run(6'h2A, 1, 3, 2, 8, 1, 0); // R2 R5 R6 flagged with stalls
    run(6'd17, 0, 2, 5, 8, 1, 1); // R6 R9 simple with poke
    run(6'd9,  1, 10, 1, 3, 0, 0); // R8 flagged timeout
    run(6'd1,  0, 1, 0, 0, 0, 0); // R8 limit zero
    run(6'h3F, 1, 0, 0, 2, 1, 1); // R2 R9 flagged top profile
    run(6'd12, 0, 3, 0, 4, 1, 0); // R8 boundary: busy one under limit
    run(6'd33, 1, 4, 3, 4, 0, 0); // R8 flagged at limit
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule